// File: doc/BRIEF.md
# I2C Controller Status, Interrupt and DMA Request Logic

This block keeps the event side of an I2C controller: a 16-bit status word, an interrupt-enable mask, a pair of DMA-enable switches, a test register and, on the older register layout, a read-to-acknowledge interrupt vector. Elsewhere in the controller, the transfer engine raises status bits through one-cycle set strobes. This block folds the status and mask into one interrupt line and into a receive and a transmit DMA request.

The parameter `LEGACY` picks the register behaviour. With `LEGACY=0` (newer layout), software clears status bits by writing ones and the mask is six bits wide. With `LEGACY=1`, status is read-only. Software acknowledges events by reading the vector register. The mask there is five bits wide. Each layout has its own software reset trigger. The block performs that reset on its own registers and also sends it to the rest of the controller as a one-cycle pulse.

Register offsets on the 3-bit `reg_addr`: 0 status, 1 interrupt enable, 2 vector, 3 DMA enable, 4 test, 5 system config, 6 control. Status bit meanings used below: bit 3 receive-ready, bit 4 transmit-ready.

Top module: `i2c_irq_dma`

## Requirements
- R1: `irq` is high exactly when some status bit and its interrupt-enable bit are both 1. It changes the cycle after the state changes.
- R2: A write to offset 1 keeps bits 5:0 when LEGACY=0 and bits 4:0 when LEGACY=1. Other bits read as 0.
- R3: With LEGACY=0, a write to offset 0 clears each status bit written as 1 among bits 0, 1, 2 and 5. Bits 3 and 4 are never cleared by it. With LEGACY=1, a write to offset 0 has no effect.
- R4: Offset 3 keeps only bit 15 (receive DMA enable) and bit 7 (transmit DMA enable). Writing bit 15 as 1 clears enable bit 3, and writing bit 7 as 1 clears enable bit 4.
- R5: `drq_rx` is status bit 3 while DMA bit 15 is set, and `drq_tx` is status bit 4 while DMA bit 7 is set. Each request is 0 while its enable is clear.
- R6: With LEGACY=1, a read of offset 2 returns the index plus 1 of the lowest bit set in status AND enable, or 0 if no such bit exists, and it clears that status bit. With LEGACY=0, offset 2 reads 0 and changes nothing.
- R7: Offset 4 keeps the bits under 0xF80F. With LEGACY=0, writing it with bit 11 set forces status bits 5:0 to 1. With LEGACY=1, no status bit is forced.
- R8: With LEGACY=0, writing offset 5 with bit 1 set resets all registers of the block to zero and pulses `sw_reset` for one cycle. With LEGACY=1, the same happens when offset 6 is written with bit 15 clear. All other writes to offsets 5 and 6 have no effect.
- R9: If a set strobe and a clear by write or vector read hit the same status bit in the same cycle, the bit ends up set.
- R10: After `rst_n` every register is zero, and `irq`, `drq_rx`, `drq_tx` and `sw_reset` are low.
- R11: A read strobe in one cycle gives `reg_rvalid` high and the register value on `reg_rdata` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| stat_set | input | 16 | One-cycle set strobes for the status bits |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | Interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |
| sw_reset | output | 1 | One-cycle pulse after a software reset |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high together. The implication checks on `irq` and the DMA requests also assume that no mask or DMA write lands in the same cycle as the strobe they follow, so those checks exclude such cycles themselves. The stimulus raises one strobe at a time, and it combines a set strobe with a clear only in the dedicated same-cycle case. Both layouts run on one shared bus, so each write is chosen to be meaningful for the two layouts at once.

// File: rtl/i2c_irq_dma_pkg.sv
package i2c_irq_dma_pkg;

  typedef enum logic [2:0] {
    OFF_STAT   = 3'd0,
    OFF_IE     = 3'd1,
    OFF_VEC    = 3'd2,
    OFF_DMA    = 3'd3,
    OFF_TEST   = 3'd4,
    OFF_SYSCFG = 3'd5,
    OFF_CTL    = 3'd6
  } reg_off_e;

  localparam int unsigned STAT_W    = 16;
  localparam int unsigned IE_W      = 6;
  localparam int unsigned BIT_RRDY  = 3;
  localparam int unsigned BIT_XRDY  = 4;
  localparam logic [15:0] SW_CLR_MASK = 16'h0027;
  localparam logic [15:0] FORCE_MASK  = 16'h003F;
  localparam logic [15:0] TEST_KEEP   = 16'hF80F;

  // enable bits kept by a mask write for each layout
  function automatic logic [IE_W-1:0] ie_keep(input bit legacy);
    return legacy ? 6'h1F : 6'h3F;
  endfunction

  // index+1 of lowest set bit, 0 when none
  function automatic logic [4:0] low_code(input logic [STAT_W-1:0] v);
    logic [4:0] c;
    c = 5'd0;
    for (int i = STAT_W - 1; i >= 0; i--) begin
      if (v[i]) c = 5'(i + 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/i2c_irq_dma_status.sv
module i2c_irq_dma_status
  import i2c_irq_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) stat_q <= '0;
    else                    stat_q <= (stat_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/i2c_irq_dma_cfg.sv
module i2c_irq_dma_cfg
  import i2c_irq_dma_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            ie_we,
  input  logic            dma_we,
  input  logic            test_we,
  input  logic [15:0]     wdata,
  output logic [IE_W-1:0] ie_q,
  output logic [1:0]      dma_q,
  output logic [15:0]     test_q
);
  localparam logic [IE_W-1:0] KEEP = ie_keep(LEGACY);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      ie_q   <= '0;
      dma_q  <= '0;
      test_q <= '0;
    end else begin
      if (ie_we) ie_q <= wdata[IE_W-1:0] & KEEP;
      if (dma_we) begin
        dma_q <= {wdata[15], wdata[7]};
        if (wdata[15]) ie_q[BIT_RRDY] <= 1'b0;
        if (wdata[7])  ie_q[BIT_XRDY] <= 1'b0;
      end
      if (test_we) test_q <= wdata & TEST_KEEP;
    end
  end
endmodule

// File: rtl/i2c_irq_dma_vector.sv
module i2c_irq_dma_vector
  import i2c_irq_dma_pkg::*;
(
  input  logic [STAT_W-1:0] pend,
  output logic [4:0]        code,
  output logic [STAT_W-1:0] pick
);
  always_comb begin
    code = low_code(pend);
    pick = '0;
    if (code != 5'd0) pick[code - 5'd1] = 1'b1;
  end
endmodule

// File: rtl/i2c_irq_dma.sv
module i2c_irq_dma
  import i2c_irq_dma_pkg::*;
#(
  parameter bit LEGACY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] stat_set,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        irq,
  output logic        drq_rx,
  output logic        drq_tx,
  output logic        sw_reset
);
  logic [STAT_W-1:0] stat_q, pend, pick, vec_clr, wr_clr, force_set, set_all;
  logic [IE_W-1:0]   ie_q;
  logic [1:0]        dma_q;
  logic [15:0]       test_q;
  logic [4:0]        vec_code;
  logic              soft_rst, vec_rd, sw_reset_q;
  logic [15:0]       rdata_q;
  logic              rvalid_q;

  assign pend    = stat_q & {{(STAT_W-IE_W){1'b0}}, ie_q};
  assign vec_rd  = LEGACY && reg_rd && (reg_addr == OFF_VEC);
  assign vec_clr = vec_rd ? pick : '0;
  assign wr_clr  = (!LEGACY && reg_wr && reg_addr == OFF_STAT) ? (reg_wdata & SW_CLR_MASK) : '0;
  assign force_set = (!LEGACY && reg_wr && reg_addr == OFF_TEST && reg_wdata[11]) ? FORCE_MASK : '0;
  assign set_all = stat_set | force_set;

  assign soft_rst = LEGACY ? (reg_wr && reg_addr == OFF_CTL && !reg_wdata[15])
                           : (reg_wr && reg_addr == OFF_SYSCFG && reg_wdata[1]);

  i2c_irq_dma_vector u_vec (.pend(pend), .code(vec_code), .pick(pick));

  i2c_irq_dma_status u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .set_vec(set_all), .clr_vec(vec_clr | wr_clr), .stat_q(stat_q)
  );

  i2c_irq_dma_cfg #(.LEGACY(LEGACY)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .ie_we(reg_wr && reg_addr == OFF_IE),
    .dma_we(reg_wr && reg_addr == OFF_DMA),
    .test_we(reg_wr && reg_addr == OFF_TEST),
    .wdata(reg_wdata), .ie_q(ie_q), .dma_q(dma_q), .test_q(test_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      sw_reset_q <= 1'b0;
    end else begin
      rvalid_q   <= reg_rd;
      sw_reset_q <= soft_rst;
      if (reg_rd) begin
        case (reg_addr)
          OFF_STAT: rdata_q <= stat_q;
          OFF_IE:   rdata_q <= {{(16-IE_W){1'b0}}, ie_q};
          OFF_VEC:  rdata_q <= LEGACY ? {11'd0, vec_code} : 16'd0;
          OFF_DMA:  rdata_q <= {dma_q[1], 7'd0, dma_q[0], 7'd0};
          OFF_TEST: rdata_q <= test_q;
          default:  rdata_q <= 16'd0;
        endcase
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign reg_rvalid = rvalid_q;
  assign sw_reset   = sw_reset_q;
  assign irq        = |pend;
  assign drq_rx     = dma_q[1] & stat_q[BIT_RRDY];
  assign drq_tx     = dma_q[0] & stat_q[BIT_XRDY];
endmodule

// File: rtl/i2c_irq_dma_chk.sv
module i2c_irq_dma_chk #(
  parameter bit LEGACY = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] stat_set,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic [15:0] stat_q,
  input logic [5:0]  ie_q,
  input logic [1:0]  dma_q,
  input logic [15:0] vec_clr,
  input logic        soft_rst,
  input logic        irq,
  input logic        drq_rx,
  input logic        drq_tx
);
  logic cfg_wr;
  assign cfg_wr = reg_wr && (reg_addr == 3'd1 || reg_addr == 3'd3);

  p_irq_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(stat_set[5:0] & ie_q)) && !soft_rst && !cfg_wr) |=> irq);

  generate if (LEGACY) begin : g_leg
    p_ie_width_r2: assert property (@(posedge clk) disable iff (!rst_n) !ie_q[5]);
  end endgenerate

  p_hw_only_rrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[3] && !soft_rst && !vec_clr[3]) |=> stat_q[3]);
  p_hw_only_xrdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[4] && !soft_rst && !vec_clr[4]) |=> stat_q[4]);

  p_dma_rx_ie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[15]) |=> !ie_q[3]);
  p_dma_tx_ie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[7]) |=> !ie_q[4]);

  p_drq_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q[1] && stat_set[3] && !soft_rst && !cfg_wr) |=> drq_rx);
  p_drq_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_q[0] && stat_set[4] && !soft_rst && !cfg_wr) |=> drq_tx);

  p_vec_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_clr));

  p_reset_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (stat_q == 16'd0 && ie_q == 6'd0 && dma_q == 2'd0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && stat_set != 16'd0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
endmodule

bind i2c_irq_dma i2c_irq_dma_chk #(.LEGACY(LEGACY)) u_chk (
  .clk(clk), .rst_n(rst_n), .stat_set(stat_set), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat_q(stat_q), .ie_q(ie_q),
  .dma_q(dma_q), .vec_clr(vec_clr), .soft_rst(soft_rst), .irq(irq),
  .drq_rx(drq_rx), .drq_tx(drq_tx)
);

// File: tb/i2c_irq_dma_test.sv
module i2c_irq_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] stat_set = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_n, rd_l;
  logic        rv_n, rv_l, irq_n, irq_l, rx_n, rx_l, tx_n, tx_l, swr_n, swr_l;

  int checks = 0, errors = 0;

  typedef struct { logic [15:0] en; logic [15:0] el; string tag; } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  i2c_irq_dma #(.LEGACY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .stat_set(stat_set), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_n), .reg_rvalid(rv_n),
    .irq(irq_n), .drq_rx(rx_n), .drq_tx(tx_n), .sw_reset(swr_n));

  i2c_irq_dma #(.LEGACY(1'b1)) uut_leg (
    .clk(clk), .rst_n(rst_n), .stat_set(stat_set), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rd_l), .reg_rvalid(rv_l),
    .irq(irq_l), .drq_rx(rx_l), .drq_tx(tx_l), .sw_reset(swr_l));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read results as they come out (R11 latency)
  always @(negedge clk) begin
    if (rv_n || rv_l) begin
      exp_t e;
      if (sb.size() == 0) chk("R11 unexpected rvalid", 16'd1, 16'd0);
      else begin
        e = sb.pop_front();
        chk({e.tag, " R11 valid"}, {14'd0, rv_l, rv_n}, 16'd3);
        chk({e.tag, " new"}, rd_n, e.en);
        chk({e.tag, " legacy"}, rd_l, e.el);
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [15:0] en, input logic [15:0] el, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    sb.push_back('{en, el, tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [15:0] s);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; stat_set = s;
    @(negedge clk);
    reg_wr = 1'b0; stat_set = '0;
  endtask

  task automatic pulse(input logic [15:0] s);
    @(negedge clk);
    stat_set = s;
    @(negedge clk);
    stat_set = '0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual hang expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 outputs", {12'd0, irq_n | irq_l, rx_n | rx_l, tx_n | tx_l, swr_n | swr_l}, 16'd0);
    rd(3'd0, 16'h0000, 16'h0000, "R10 status");
    rd(3'd1, 16'h0000, 16'h0000, "R10 ie");
    // R2 mask width
    wr(3'd1, 16'hFFFF, 16'h0);
    rd(3'd1, 16'h003F, 16'h001F, "R2 ie");
    // R1 irq
    pulse(16'h0001);
    chk("R1 irq", {14'd0, irq_l, irq_n}, 16'd3);
    // R3 status write
    wr(3'd0, 16'h0001, 16'h0);
    rd(3'd0, 16'h0000, 16'h0001, "R3 w1c");
    chk("R1 irq after clear", {14'd0, irq_l, irq_n}, 16'd2);
    pulse(16'h0018);
    wr(3'd0, 16'hFFFF, 16'h0);
    rd(3'd0, 16'h0018, 16'h0019, "R3 hw-only bits");
    // R6 vector
    rd(3'd2, 16'h0000, 16'h0001, "R6 vec first");
    rd(3'd2, 16'h0000, 16'h0004, "R6 vec second");
    rd(3'd0, 16'h0018, 16'h0010, "R6 status after vec");
    // R4 DMA
    wr(3'd3, 16'hFFFF, 16'h0);
    rd(3'd3, 16'h8080, 16'h8080, "R4 dma");
    rd(3'd1, 16'h0027, 16'h0007, "R4 ie cleared");
    // R5 requests
    chk("R5 drq", {12'd0, rx_n, tx_n, rx_l, tx_l}, 16'b1101);
    wr(3'd3, 16'h0000, 16'h0);
    chk("R5 drq off", {12'd0, rx_n, tx_n, rx_l, tx_l}, 16'b0000);
    // R9 set wins over clear
    wr(3'd0, 16'h0002, 16'h0002);
    rd(3'd0, 16'h001A, 16'h0012, "R9 set wins");
    // R7 test
    wr(3'd4, 16'hFFFF, 16'h0);
    rd(3'd4, 16'hF80F, 16'hF80F, "R7 test keep");
    rd(3'd0, 16'h003F, 16'h0012, "R7 force");
    chk("R1 irq forced", {14'd0, irq_l, irq_n}, 16'd3);
    // R8 new-layout reset via system config
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'h0002;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 sw_reset pulse", {14'd0, swr_l, swr_n}, 16'd1);
    @(negedge clk);
    chk("R8 sw_reset ends", {14'd0, swr_l, swr_n}, 16'd0);
    rd(3'd0, 16'h0000, 16'h0012, "R8 status after cfg reset");
    rd(3'd1, 16'h0000, 16'h0007, "R8 ie after cfg reset");
    // R8 legacy reset via control
    pulse(16'h0004);
    wr(3'd6, 16'h8000, 16'h0);
    rd(3'd0, 16'h0004, 16'h0016, "R8 ctl enabled no reset");
    wr(3'd6, 16'h0000, 16'h0);
    rd(3'd0, 16'h0004, 16'h0000, "R8 ctl disable reset");
    rd(3'd4, 16'h0000, 16'h0000, "R8 test after resets");
    repeat (2) @(negedge clk);
    chk("R11 queue drained", 16'(sb.size()), 16'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule